// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block supervises a multi-rate clock recovery loop from the digital side. A recovered bit clock is divided down according to a two-bit rate code, so that it nominally runs at the reference frequency. Its cycles are counted over a fixed window of reference cycles. The count is moved into the reference domain and compared with the nominal value, and the absolute difference (in counts, each about 30.5 ppm with the default 2^15-cycle window) decides the loop mode.

Two thresholds give hysteresis. A trial of data tracking becomes a declared lock only when the error is within the tight entry tolerance. A declared lock is dropped only when the error exceeds the wider exit tolerance, or when a window ends without any answer from the recovered-clock side. While it is not locked, the block steers the loop onto the local reference. After a programmable number of windows it switches back to data tracking for a one-window trial.

A lost input signal, a forced-reference request and reset all override the measurement at once. While the input signal is missing, the serial data is also held at zero.

Top module: `freq_lock_det`

## Requirements
- R1: While `rst` is high, `locked` is 0 and `track_ref` is 1.
- R2: Rate code `rate_sel` divides the recovered clock by 16 for 2'b00, by 8 for 2'b10, by 4 for 2'b01 and by 1 for 2'b11. A recovered clock at exactly divider × reference frequency reaches `locked`=1 under every code.
- R3: A measurement covers 2^WIN_LOG2 reference cycles, and the loop mode changes only when a measurement result arrives, so successive mode changes caused by measurements are one window apart.
- R4: From a data-tracking trial, `locked` rises only if |count − 2^WIN_LOG2| ≤ ENTER_TOL. An error above ENTER_TOL never produces a lock.
- R5: Once locked, an error up to EXIT_TOL keeps the lock, and an error above EXIT_TOL drops it at that result.
- R6: A window that ends with no answer from the recovered-clock side (recovered clock stopped) drops the lock.
- R7: `track_ref` is 1 whenever the loop is not tracking data; `locked`=1 implies `track_ref`=0.
- R8: After dropping out, the block stays in reference mode for RETRY_WIN results and then tries data tracking (`track_ref`=0) for one window, repeating while the error stays out of band.
- R9: With `sig_det_n`=1 (input lost), `locked`=0 and `track_ref`=1 in the same cycle. After `sig_det_n` returns low, lock is reacquired through the retry sequence.
- R10: With `force_ref_n`=0, `locked`=0 and `track_ref`=1 regardless of the measurement. After release, lock is reacquired.
- R11: `ser_out` equals `ser_in` while `sig_det_n`=0, and is 0 while `sig_det_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock; all decisions are made in this domain |
| rec_clk | input | 1 | Recovered bit clock from the loop oscillator |
| rst | input | 1 | Asynchronous reset, active high |
| rate_sel | input | 2 | Line-rate code selecting the recovered-clock divider |
| sig_det_n | input | 1 | Input signal present when low |
| force_ref_n | input | 1 | Forces reference tracking when low |
| ser_in | input | 1 | Serial data from the input stage |
| ser_out | output | 1 | Serial data, held at zero while the signal is lost |
| locked | output | 1 | High while lock to data is declared |
| track_ref | output | 1 | High when the loop must follow the reference |

## Verification
The recovered clock is driven at the exact nominal ratio under each of the four rate codes; this separates a correct divider mapping from a swapped one. It is then offset so that the count lands between the two tolerances, on both the slow and the fast side. The lock must survive this offset, but the same offset must never start a lock, which isolates the hysteresis from a single-threshold design. Offsets beyond the exit tolerance and a stopped recovered clock exercise loss of lock, and the spacing of the retry trials is timed. Signal loss and forced-reference requests are applied while locked, to show that they override the measurement and that lock is reacquired afterwards.

// File: rtl/freq_lock_det.sv
module freq_lock_det #(
  parameter int WIN_LOG2  = 15,
  parameter int ENTER_TOL = 10,
  parameter int EXIT_TOL  = 20,
  parameter int RETRY_WIN = 4
) (
  input  logic       ref_clk,
  input  logic       rec_clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic       sig_det_n,
  input  logic       force_ref_n,
  input  logic       ser_in,
  output logic       ser_out,
  output logic       locked,
  output logic       track_ref
);
  localparam int CW = WIN_LOG2 + 2;
  localparam int RW = (RETRY_WIN > 1) ? $clog2(RETRY_WIN) : 1;
  localparam logic [CW-1:0] NOMINAL = CW'(2 ** WIN_LOG2);
  localparam logic [CW-1:0] ENTER_C = CW'(ENTER_TOL);
  localparam logic [CW-1:0] EXIT_C  = CW'(EXIT_TOL);
  localparam logic [RW-1:0] WAIT_END = RW'(RETRY_WIN - 1);

  typedef enum logic [1:0] {S_REF, S_TRY, S_LOCK} mode_t;

  logic [WIN_LOG2-1:0] win;
  logic req_t, ack_m, ack_s, ack_d, pending, have_prev;
  logic lost_m, lost_s, frc_m, frc_s;
  logic [CW-1:0] prev;
  mode_t state;
  logic [RW-1:0] wait_n;

  logic [1:0] rate_m, rate_s;
  logic [3:0] pre, pre_top;
  logic [CW-1:0] rec_cnt, snap;
  logic req_m, req_s, req_d, ack_t;

  // recovered-clock side: divider, free-running count, snapshot on request
  always_comb begin
    case (rate_s)
      2'b00:   pre_top = 4'd15;
      2'b10:   pre_top = 4'd7;
      2'b01:   pre_top = 4'd3;
      default: pre_top = 4'd0;
    endcase
  end

  always_ff @(posedge rec_clk or posedge rst) begin
    if (rst) begin
      rate_m  <= 2'b11;
      rate_s  <= 2'b11;
      pre     <= '0;
      rec_cnt <= '0;
      req_m   <= 1'b0;
      req_s   <= 1'b0;
      req_d   <= 1'b0;
      snap    <= '0;
      ack_t   <= 1'b0;
    end else begin
      rate_m <= rate_sel;
      rate_s <= rate_m;
      req_m  <= req_t;
      req_s  <= req_m;
      req_d  <= req_s;
      if (pre >= pre_top) begin
        pre     <= '0;
        rec_cnt <= rec_cnt + 1'b1;
      end else begin
        pre <= pre + 4'd1;
      end
      if (req_s != req_d) begin
        snap  <= rec_cnt;
        ack_t <= req_s;
      end
    end
  end

  // reference side: window, handshake, error
  logic tick, got, miss, ovr, meas_vld, result;
  logic [CW-1:0] meas, dev;

  assign tick     = &win;
  assign got      = ack_s ^ ack_d;
  assign miss     = tick & pending & ~got;
  assign ovr      = lost_s | frc_s;
  assign meas     = snap - prev;
  assign dev      = (meas >= NOMINAL) ? meas - NOMINAL : NOMINAL - meas;
  assign meas_vld = got & have_prev;
  assign result   = meas_vld | miss;

  always_ff @(posedge ref_clk or posedge rst) begin
    if (rst) begin
      win       <= '0;
      req_t     <= 1'b0;
      ack_m     <= 1'b0;
      ack_s     <= 1'b0;
      ack_d     <= 1'b0;
      pending   <= 1'b0;
      have_prev <= 1'b0;
      prev      <= '0;
      lost_m    <= 1'b1;
      lost_s    <= 1'b1;
      frc_m     <= 1'b0;
      frc_s     <= 1'b0;
    end else begin
      win    <= win + 1'b1;
      ack_m  <= ack_t;
      ack_s  <= ack_m;
      ack_d  <= ack_s;
      lost_m <= sig_det_n;
      lost_s <= lost_m;
      frc_m  <= ~force_ref_n;
      frc_s  <= frc_m;
      if (tick) begin
        req_t   <= ~req_t;
        pending <= 1'b1;
      end else if (got) begin
        pending <= 1'b0;
      end
      if (got) begin
        prev      <= snap;
        have_prev <= 1'b1;
      end
    end
  end

  always_ff @(posedge ref_clk or posedge rst) begin
    if (rst) begin
      state  <= S_REF;
      wait_n <= '0;
    end else if (ovr) begin
      state  <= S_REF;
      wait_n <= '0;
    end else begin
      case (state)
        S_REF: if (result) begin
          if (wait_n == WAIT_END) begin
            state  <= S_TRY;
            wait_n <= '0;
          end else begin
            wait_n <= wait_n + 1'b1;
          end
        end
        S_TRY: if (miss) state <= S_REF;
               else if (meas_vld) state <= (dev <= ENTER_C) ? S_LOCK : S_REF;
        S_LOCK: if (miss || (meas_vld && dev > EXIT_C)) state <= S_REF;
        default: state <= S_REF;
      endcase
    end
  end

  assign ser_out   = ser_in & ~sig_det_n;
  assign locked    = (state == S_LOCK) & ~sig_det_n & force_ref_n;
  assign track_ref = (state == S_REF) | sig_det_n | ~force_ref_n;

  AST_STATE_ON_RESULT: assert property (@(posedge ref_clk) disable iff (rst)
    (state != $past(state)) |-> $past(result || ovr)); // R3
  AST_ENTER_TIGHT: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(state == S_LOCK) |-> $past(state == S_TRY && meas_vld && dev <= ENTER_C)); // R4
  AST_EXIT_WIDE: assert property (@(posedge ref_clk) disable iff (rst)
    (state == S_LOCK && !ovr && meas_vld && dev > EXIT_C) |=> state == S_REF); // R5
  AST_HOLD_IN_BAND: assert property (@(posedge ref_clk) disable iff (rst)
    (state == S_LOCK && !ovr && meas_vld && dev <= EXIT_C) |=> state == S_LOCK); // R5
  AST_MISS_DROPS: assert property (@(posedge ref_clk) disable iff (rst)
    (state == S_LOCK && miss) |=> state == S_REF); // R6
  AST_OVERRIDE_REF: assert property (@(posedge ref_clk) disable iff (rst)
    ovr |=> state == S_REF); // R9
endmodule

// File: tb/freq_lock_det_tb.sv
`timescale 1ns/1ps
module freq_lock_det_tb;
  localparam real CLK_NS = 10.0;
  localparam int  WL = 8;
  localparam int  W = 2 ** WL;
  localparam int  RETRY = 2;

  logic ref_clk = 1'b0, rec_clk = 1'b0, rst = 1'b1;
  logic [1:0] rate_sel = 2'b11;
  logic sig_det_n = 1'b0, force_ref_n = 1'b1, ser_in = 1'b0;
  logic ser_out, locked, track_ref;
  real rec_half = 5.0;
  bit rec_run = 1'b1;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  freq_lock_det #(.WIN_LOG2(WL), .ENTER_TOL(10), .EXIT_TOL(20), .RETRY_WIN(RETRY)) u_dut (
    .ref_clk(ref_clk), .rec_clk(rec_clk), .rst(rst), .rate_sel(rate_sel),
    .sig_det_n(sig_det_n), .force_ref_n(force_ref_n), .ser_in(ser_in),
    .ser_out(ser_out), .locked(locked), .track_ref(track_ref));

  always #(CLK_NS / 2.0) ref_clk = ~ref_clk;
  always begin
    if (rec_run) #(rec_half) rec_clk = ~rec_clk;
    else #(CLK_NS);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle behavioural model of the overrides and output relations
  always @(negedge ref_clk) begin
    if (!rst && !finished) begin
      checks++;
      if (locked && track_ref) begin
        errors++; $display("FAIL R7 locked with track_ref actual=1 expected=0");
      end
      if (sig_det_n && (locked || !track_ref || ser_out)) begin
        errors++; $display("FAIL R9/R11 signal lost actual=%0b%0b%0b expected=010", locked, track_ref, ser_out);
      end
      if (!force_ref_n && (locked || !track_ref)) begin
        errors++; $display("FAIL R10 forced actual=%0b%0b expected=01", locked, track_ref);
      end
      if (!sig_det_n && ser_out !== ser_in) begin
        errors++; $display("FAIL R11 ser_out actual=%0b expected=%0b", ser_out, ser_in);
      end
    end
  end

  function automatic int div_of(input logic [1:0] c);
    case (c)
      2'b00: return 16;
      2'b10: return 8;
      2'b01: return 4;
      default: return 1;
    endcase
  endfunction

  task automatic set_rate(input logic [1:0] c, input int count);
    @(posedge ref_clk);
    rate_sel = c;
    rec_half = (CLK_NS / 2.0) * real'(W) / (real'(count) * real'(div_of(c)));
  endtask

  function automatic logic sig(input int sel);
    return (sel == 0) ? locked : track_ref;
  endfunction

  task automatic wait_for(input int sel, input logic val, input int max, output int n);
    n = 0;
    while (n < max && sig(sel) !== val) begin
      @(negedge ref_clk);
      n++;
    end
  endtask

  task automatic hold(input int cyc, output bit seen_lock, output bit seen_unlock);
    seen_lock = 0; seen_unlock = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge ref_clk);
      if (locked) seen_lock = 1; else seen_unlock = 1;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    bit sl, su;
    ser_in = 1'b1;
    repeat (3) @(negedge ref_clk);
    check(locked == 0 && track_ref == 1, "R1 reset state", {locked, track_ref}, 1);
    @(posedge ref_clk); rst = 1'b0;

    // first lock at rate code 11, timing of trial to lock
    wait_for(1, 1'b0, 8 * W, n);
    check(track_ref == 0, "R8 first data trial", track_ref, 0);
    wait_for(0, 1'b1, 2 * W, n);
    check(locked == 1, "R2 lock code 11", locked, 1);
    check(n >= W - 3 && n <= W + 3, "R3 trial lasts one window", n, W);

    begin
      logic [1:0] codes [3] = '{2'b00, 2'b10, 2'b01};
      foreach (codes[k]) begin
        set_rate(codes[k], W);
        repeat (3 * W) @(negedge ref_clk);
        wait_for(0, 1'b1, 6 * W, n);
        check(locked == 1, $sformatf("R2 lock code %b", codes[k]), locked, 1);
        hold(2 * W, sl, su);
        check(!su, $sformatf("R2 lock held code %b", codes[k]), su, 0);
      end
    end
    set_rate(2'b11, W);
    repeat (3 * W) @(negedge ref_clk);
    wait_for(0, 1'b1, 6 * W, n);
    check(locked == 1, "R2 relock code 11", locked, 1);

    // hysteresis: in-between error keeps lock on both sides
    set_rate(2'b11, W - 15);
    hold(4 * W, sl, su);
    check(!su, "R5 slow in-band offset keeps lock", su, 0);
    set_rate(2'b11, W + 15);
    hold(4 * W, sl, su);
    check(!su, "R5 fast in-band offset keeps lock", su, 0);

    set_rate(2'b11, W - 30);
    wait_for(0, 1'b0, 3 * W, n);
    check(locked == 0, "R5 beyond exit drops lock", locked, 0);

    // retry spacing while far off
    wait_for(1, 1'b0, (RETRY + 3) * W, n);
    check(track_ref == 0, "R8 retry trial starts", track_ref, 0);
    wait_for(1, 1'b1, 2 * W, n);
    check(n >= W - 3 && n <= W + 3, "R8 failed trial one window", n, W);
    wait_for(1, 1'b0, (RETRY + 2) * W, n);
    check(n >= RETRY * W - 3 && n <= RETRY * W + 3, "R8 retry interval", n, RETRY * W);

    // in-between error never starts a lock
    set_rate(2'b11, W - 15);
    hold(8 * W, sl, su);
    check(!sl, "R4 slow in-band offset never locks", sl, 0);
    set_rate(2'b11, W + 15);
    hold(6 * W, sl, su);
    check(!sl, "R4 fast in-band offset never locks", sl, 0);
    set_rate(2'b11, W + 4);
    wait_for(0, 1'b1, 6 * W, n);
    check(locked == 1, "R4 small error locks", locked, 1);

    // recovered clock stops
    @(posedge ref_clk); rec_run = 1'b0;
    wait_for(0, 1'b0, 3 * W, n);
    check(locked == 0, "R6 dead recovered clock drops lock", locked, 0);
    hold(3 * W, sl, su);
    check(!sl, "R6 no lock while dead", sl, 0);
    @(posedge ref_clk); rec_run = 1'b1; set_rate(2'b11, W);
    wait_for(0, 1'b1, 8 * W, n);
    check(locked == 1, "R6 relock after restart", locked, 1);

    // signal loss
    @(posedge ref_clk); sig_det_n = 1'b1; ser_in = 1'b1;
    @(negedge ref_clk);
    check(locked == 0 && track_ref == 1, "R9 loss overrides lock", {locked, track_ref}, 1);
    check(ser_out == 0, "R11 data zero on loss", ser_out, 0);
    hold(2 * W, sl, su);
    check(!sl, "R9 no lock during loss", sl, 0);
    @(posedge ref_clk); sig_det_n = 1'b0;
    @(negedge ref_clk);
    check(ser_out == 1, "R11 data passes", ser_out, 1);
    wait_for(0, 1'b1, 6 * W, n);
    check(locked == 1, "R9 relock after loss", locked, 1);

    // forced reference
    @(posedge ref_clk); force_ref_n = 1'b0; ser_in = 1'b1;
    @(negedge ref_clk);
    check(locked == 0 && track_ref == 1, "R10 force overrides lock", {locked, track_ref}, 1);
    check(ser_out == 1, "R11 data passes under force", ser_out, 1);
    hold(2 * W, sl, su);
    check(!sl, "R10 no lock during force", sl, 0);
    @(posedge ref_clk); force_ref_n = 1'b1;
    wait_for(0, 1'b1, 6 * W, n);
    check(locked == 1, "R10 relock after force", locked, 1);

    @(posedge ref_clk); rst = 1'b1;
    @(negedge ref_clk);
    check(locked == 0 && track_ref == 1, "R1 reset while locked", {locked, track_ref}, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule